// File: doc/BRIEF.md
# Flash Read Prefetch Buffer

This block sits between a memory-mapped read port and a serial flash sequencer. A reader presents a byte address and receives the 32-bit word that contains it. If that word lies in the line the buffer currently holds, it comes back in the same cycle. Otherwise the held line is dropped. The block then issues one fetch request to the sequencer, carrying a programmable sequence identifier, the word-aligned start address and a byte length. The sequencer streams the line back one word at a time.

The fetch length is set in units of 8 bytes and is limited to the buffer capacity. A unit count of 128 selects the full 1024-byte buffer. While a line is arriving, a read waits only until its own word has landed. Reads of words already delivered complete without any new request.

After software changes the flash contents, the buffer has to be emptied. This is done by raising both soft-reset strobes, one for the bus side and one for the flash side, and holding them together for a minimum number of cycles. A configuration bit chooses whether each returned word is byte-reversed.

Top module: `rd_prefetch_buf`

## Requirements
- R1: After reset, `fill_busy`, `fq_valid` and `rd_ready` are low, and the buffer holds no valid line.
- R2: A read that the held line does not cover raises exactly one fetch request. The request carries `cfg_seq`, the read address with bits [1:0] cleared, and the configured length.
- R3: The fetch length in bytes is `cfg_units`×8. A unit count of 0 gives 8 bytes. Any count whose product exceeds the buffer size (1024 bytes by default, reached at 128) gives the buffer size.
- R4: `rd_data` is the word at the aligned address, with the flash byte at address+k on bits [8k+7:8k] when `cfg_swap` is 0. When `cfg_swap` is 1, the byte order is reversed.
- R5: A read whose address lies in [base, base+length) of a valid line sees `rd_ready` high in its first cycle, and no request is made.
- R6: While a line is arriving, a read inside that line holds `rd_ready` low until its word has been received. It then completes without a new request.
- R7: `fill_busy` is high from the cycle a miss is taken until the cycle after the last word of the line is accepted, and every word of the requested length is absorbed.
- R8: Holding `inv_bus` and `inv_flash` high together for INV_HOLD (3) consecutive cycles invalidates the held line, so the next read of it misses.
- R9: Either strobe alone, or both together for fewer than INV_HOLD cycles, has no effect on the held line.
- R10: A miss replaces the held line: the address just past the line misses, and the old line then misses too.
- R11: An invalidation that completes while a line is arriving lets the remaining words be absorbed, but the line is not kept, and a later read of it misses.
- R12: Once raised, `fq_valid` stays high with unchanged sequence, address and length until `fq_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_units | input | 8 | Fetch length in 8-byte units |
| cfg_seq | input | 4 | Sequence identifier used for refills |
| cfg_swap | input | 1 | Byte-reverse returned words |
| inv_bus | input | 1 | Bus-side soft-reset strobe |
| inv_flash | input | 1 | Flash-side soft-reset strobe |
| rd_valid | input | 1 | Read request, held until rd_ready |
| rd_addr | input | 32 | Read byte address |
| rd_ready | output | 1 | Read data valid this cycle |
| rd_data | output | 32 | Read data word |
| fq_valid | output | 1 | Fetch request to sequencer |
| fq_ready | input | 1 | Sequencer accepts the request |
| fq_seq | output | 4 | Sequence identifier of the request |
| fq_addr | output | 32 | Word-aligned start address |
| fq_len | output | 11 | Fetch length in bytes |
| fd_valid | input | 1 | Fetched word valid |
| fd_data | input | 32 | Fetched word |
| fill_busy | output | 1 | A refill is outstanding |

## Verification
The bench uses the default parameters: a 1024-byte buffer, 8-bit unit count and an invalidate hold of 3 cycles. With these defaults, the clamp at 128 units and above is reachable, as is the zero-unit floor. A full 256-word line can be swept word by word for hits. A sequencer stub delivers words with a gap in every third cycle, so reads that overtake the fill and invalidations that land mid-fill fall inside long fill windows. Invalidate pulses one cycle short of the hold time exercise the exact threshold.

// File: rtl/rpb_pkg.sv
package rpb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_FILL = 2'd2
    } fill_st_e;

    function automatic logic [31:0] swap32(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/rpb_store.sv
module rpb_store #(
    parameter int WORDS = 256,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_data
);
    logic [31:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/rpb_lookup.sv
module rpb_lookup #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 11,
    parameter int IDX_W  = 8,
    parameter int CNT_W  = 9
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] line_base,
    input  logic [LEN_W-1:0]  line_len,
    input  logic [CNT_W-1:0]  line_filled,
    input  logic              line_live,
    output logic              covered,
    output logic [IDX_W-1:0]  word_idx
);
    logic [ADDR_W-1:0] offset;
    logic              in_range;
    logic              arrived;

    always_comb begin
        // Addresses below the base wrap to a huge offset and fall out of range.
        offset   = rd_addr - line_base;
        in_range = offset < {{(ADDR_W-LEN_W){1'b0}}, line_len};
        word_idx = offset[IDX_W+1:2];
        arrived  = {1'b0, word_idx} < line_filled;
        covered  = line_live && in_range && arrived;
    end
endmodule

// File: rtl/rpb_inv.sv
module rpb_inv #(
    parameter int HOLD = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inv_bus,
    input  logic inv_flash,
    output logic inv_fire
);
    localparam int CW = $clog2(HOLD + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          both;

    always_comb begin
        both     = inv_bus && inv_flash;
        inv_fire = both && (cnt_q == CW'(HOLD - 1));
        if (!both) begin
            cnt_d = '0;
        end else if (cnt_q == CW'(HOLD)) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/rpb_ctrl.sv
module rpb_ctrl
    import rpb_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BUF_BYTES = 1024,
    parameter int UNIT_W    = 8,
    parameter int SEQ_W     = 4,
    parameter int LEN_W     = 11,
    parameter int IDX_W     = 8,
    parameter int CNT_W     = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              covered,
    input  logic [UNIT_W-1:0] cfg_units,
    input  logic [SEQ_W-1:0]  cfg_seq,
    input  logic              inv_fire,
    input  logic              fq_ready,
    input  logic              fd_valid,
    output logic              fq_valid,
    output logic [SEQ_W-1:0]  fq_seq,
    output logic [ADDR_W-1:0] fq_addr,
    output logic [LEN_W-1:0]  fq_len,
    output logic              busy,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [ADDR_W-1:0] line_base,
    output logic [LEN_W-1:0]  line_len,
    output logic [CNT_W-1:0]  line_filled,
    output logic              line_live
);
    localparam int RAW_W = UNIT_W + 3;

    typedef struct packed {
        fill_st_e          st;
        logic              valid;
        logic              kill;
        logic [ADDR_W-1:0] base;
        logic [LEN_W-1:0]  len;
        logic [CNT_W-1:0]  filled;
        logic [SEQ_W-1:0]  seq;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: ST_IDLE, valid: 1'b0, kill: 1'b0,
                                 base: '0, len: '0, filled: '0, seq: '0};

    ctl_t             d, q;
    logic [RAW_W-1:0] raw_len;
    logic [LEN_W-1:0] new_len;
    logic [CNT_W-1:0] line_words;

    // Length of the next fetch, floored at one unit and capped at the buffer size.
    always_comb begin
        raw_len = {cfg_units, 3'b000};
        if (cfg_units == '0) begin
            new_len = LEN_W'(8);
        end else if (int'(raw_len) > BUF_BYTES) begin
            new_len = LEN_W'(BUF_BYTES);
        end else begin
            new_len = LEN_W'(raw_len);
        end
    end

    always_comb begin
        d          = q;
        wr_en      = 1'b0;
        line_words = CNT_W'(q.len >> 2);
        case (q.st)
            ST_IDLE: begin
                if (inv_fire) begin
                    d.valid = 1'b0;
                end
                if (rd_valid && !covered) begin
                    d.st     = ST_REQ;
                    d.valid  = 1'b0;
                    d.kill   = 1'b0;
                    d.base   = {rd_addr[ADDR_W-1:2], 2'b00};
                    d.len    = new_len;
                    d.seq    = cfg_seq;
                    d.filled = '0;
                end
            end
            ST_REQ: begin
                if (inv_fire) begin
                    d.kill = 1'b1;
                end
                if (fq_ready) begin
                    d.st = ST_FILL;
                end
            end
            ST_FILL: begin
                if (inv_fire) begin
                    d.kill = 1'b1;
                end
                if (fd_valid) begin
                    wr_en    = 1'b1;
                    d.filled = q.filled + 1'b1;
                    if (q.filled + 1'b1 == line_words) begin
                        d.st    = ST_IDLE;
                        d.valid = !(q.kill || inv_fire);
                    end
                end
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= CTL_RST;
        end else begin
            q <= d;
        end
    end

    assign fq_valid    = (q.st == ST_REQ);
    assign fq_seq      = q.seq;
    assign fq_addr     = q.base;
    assign fq_len      = q.len;
    assign busy        = (q.st != ST_IDLE);
    assign wr_idx      = q.filled[IDX_W-1:0];
    assign line_base   = q.base;
    assign line_len    = q.len;
    assign line_filled = q.filled;
    assign line_live   = q.valid || ((q.st == ST_FILL) && !q.kill);
endmodule

// File: rtl/rd_prefetch_buf.sv
module rd_prefetch_buf
    import rpb_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BUF_BYTES = 1024,
    parameter int UNIT_W    = 8,
    parameter int SEQ_W     = 4,
    parameter int INV_HOLD  = 3,
    localparam int WORDS    = BUF_BYTES / 4,
    localparam int IDX_W    = $clog2(WORDS),
    localparam int CNT_W    = IDX_W + 1,
    localparam int LEN_W    = $clog2(BUF_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [UNIT_W-1:0] cfg_units,
    input  logic [SEQ_W-1:0]  cfg_seq,
    input  logic              cfg_swap,
    input  logic              inv_bus,
    input  logic              inv_flash,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_ready,
    output logic [31:0]       rd_data,
    output logic              fq_valid,
    input  logic              fq_ready,
    output logic [SEQ_W-1:0]  fq_seq,
    output logic [ADDR_W-1:0] fq_addr,
    output logic [LEN_W-1:0]  fq_len,
    input  logic              fd_valid,
    input  logic [31:0]       fd_data,
    output logic              fill_busy
);
    logic              inv_fire;
    logic              covered;
    logic [IDX_W-1:0]  word_idx;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [ADDR_W-1:0] line_base;
    logic [LEN_W-1:0]  line_len;
    logic [CNT_W-1:0]  line_filled;
    logic              line_live;
    logic [31:0]       raw_word;

    rpb_inv #(.HOLD(INV_HOLD)) u_inv (
        .clk       (clk),
        .rst_n     (rst_n),
        .inv_bus   (inv_bus),
        .inv_flash (inv_flash),
        .inv_fire  (inv_fire)
    );

    rpb_lookup #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .IDX_W  (IDX_W),
        .CNT_W  (CNT_W)
    ) u_lookup (
        .rd_addr     (rd_addr),
        .line_base   (line_base),
        .line_len    (line_len),
        .line_filled (line_filled),
        .line_live   (line_live),
        .covered     (covered),
        .word_idx    (word_idx)
    );

    rpb_ctrl #(
        .ADDR_W    (ADDR_W),
        .BUF_BYTES (BUF_BYTES),
        .UNIT_W    (UNIT_W),
        .SEQ_W     (SEQ_W),
        .LEN_W     (LEN_W),
        .IDX_W     (IDX_W),
        .CNT_W     (CNT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_valid    (rd_valid),
        .rd_addr     (rd_addr),
        .covered     (covered),
        .cfg_units   (cfg_units),
        .cfg_seq     (cfg_seq),
        .inv_fire    (inv_fire),
        .fq_ready    (fq_ready),
        .fd_valid    (fd_valid),
        .fq_valid    (fq_valid),
        .fq_seq      (fq_seq),
        .fq_addr     (fq_addr),
        .fq_len      (fq_len),
        .busy        (fill_busy),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .line_base   (line_base),
        .line_len    (line_len),
        .line_filled (line_filled),
        .line_live   (line_live)
    );

    rpb_store #(.WORDS(WORDS), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (fd_data),
        .rd_idx  (word_idx),
        .rd_data (raw_word)
    );

    assign rd_ready = rd_valid && covered;
    assign rd_data  = cfg_swap ? swap32(raw_word) : raw_word;
endmodule

// File: rtl/rpb_chk.sv
module rpb_chk #(
    parameter int ADDR_W    = 32,
    parameter int BUF_BYTES = 1024,
    parameter int SEQ_W     = 4,
    parameter int LEN_W     = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic              fq_valid,
    input logic              fq_ready,
    input logic [SEQ_W-1:0]  fq_seq,
    input logic [ADDR_W-1:0] fq_addr,
    input logic [LEN_W-1:0]  fq_len,
    input logic              fill_busy
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fq_valid && !fq_ready |=> fq_valid && $stable(fq_addr) && $stable(fq_len) && $stable(fq_seq)); // R12
    AST_LEN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        fq_valid |-> (fq_len >= LEN_W'(8)) && (fq_len <= LEN_W'(BUF_BYTES)) && (fq_len[2:0] == 3'b000)); // R3
    AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        fq_valid |-> fill_busy); // R7
    AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> rd_valid); // R5
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        fq_valid |-> (fq_addr[1:0] == 2'b00)); // R2
    AST_SERVE_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> !fq_valid); // R6
endmodule

bind rd_prefetch_buf rpb_chk #(
    .ADDR_W    (ADDR_W),
    .BUF_BYTES (BUF_BYTES),
    .SEQ_W     (SEQ_W),
    .LEN_W     (LEN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .fq_valid  (fq_valid),
    .fq_ready  (fq_ready),
    .fq_seq    (fq_seq),
    .fq_addr   (fq_addr),
    .fq_len    (fq_len),
    .fill_busy (fill_busy)
);

// File: tb/rd_prefetch_buf_bench.sv
module rd_prefetch_buf_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_units = 8'd4;
    logic [3:0]  cfg_seq = 4'd5;
    logic        cfg_swap = 1'b0;
    logic        inv_bus = 1'b0;
    logic        inv_flash = 1'b0;
    logic        rd_valid = 1'b0;
    logic [31:0] rd_addr = '0;
    logic        rd_ready;
    logic [31:0] rd_data;
    logic        fq_valid;
    logic        fq_ready;
    logic [3:0]  fq_seq;
    logic [31:0] fq_addr;
    logic [10:0] fq_len;
    logic        fd_valid;
    logic [31:0] fd_data;
    logic        fill_busy;

    int total = 0;
    int bad = 0;
    bit done = 0;

    rd_prefetch_buf u_rd_prefetch_buf (
        .clk(clk), .rst_n(rst_n), .cfg_units(cfg_units), .cfg_seq(cfg_seq),
        .cfg_swap(cfg_swap), .inv_bus(inv_bus), .inv_flash(inv_flash),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
        .fq_valid(fq_valid), .fq_ready(fq_ready), .fq_seq(fq_seq), .fq_addr(fq_addr),
        .fq_len(fq_len), .fd_valid(fd_valid), .fd_data(fd_data), .fill_busy(fill_busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] fbyte(input logic [31:0] x);
        return x[7:0] ^ x[15:8] ^ 8'h3C;
    endfunction

    function automatic logic [31:0] fword(input logic [31:0] a);
        logic [31:0] w = {a[31:2], 2'b00};
        return {fbyte(w + 3), fbyte(w + 2), fbyte(w + 1), fbyte(w)};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Sequencer stub: accepts a request after one wait cycle, streams words with a gap every third cycle.
    logic        dly_q, s_busy, prev_v;
    logic [31:0] s_addr, prev_addr;
    int          s_left, s_tick, req_cnt, fd_cnt;
    logic [3:0]  last_seq;
    logic [31:0] last_addr;
    int          last_len;

    assign fq_ready = fq_valid && dly_q;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_q <= 1'b0; s_busy <= 1'b0; fd_valid <= 1'b0; fd_data <= '0;
            s_addr <= '0; s_left <= 0; s_tick <= 0; prev_v <= 1'b0; prev_addr <= '0;
            req_cnt = 0; fd_cnt = 0; last_seq = '0; last_addr = '0; last_len = 0;
        end else begin
            if (fd_valid) fd_cnt++;
            prev_v    <= fq_valid && !fq_ready;
            prev_addr <= fq_addr;
            dly_q     <= fq_valid && !fq_ready;
            fd_valid  <= 1'b0;
            if (fq_valid && fq_ready) begin
                chk(prev_v && prev_addr == fq_addr, "R12 request held until accepted", fq_addr, prev_addr);
                req_cnt++;
                last_seq = fq_seq; last_addr = fq_addr; last_len = int'(fq_len);
                s_busy <= 1'b1; s_addr <= fq_addr; s_left <= int'(fq_len) / 4; s_tick <= 0;
            end else if (s_busy) begin
                s_tick <= s_tick + 1;
                if (s_tick % 3 != 2) begin
                    fd_valid <= 1'b1;
                    fd_data  <= fword(s_addr);
                    s_addr   <= s_addr + 4;
                    s_left   <= s_left - 1;
                    if (s_left == 1) s_busy <= 1'b0;
                end
            end
        end
    end

    task automatic rd(input logic [31:0] a, output logic [31:0] d, output int w);
        w = 0;
        @(negedge clk);
        rd_valid = 1'b1; rd_addr = a;
        #1;
        while (!rd_ready && w < 4000) begin
            @(negedge clk); #1; w++;
        end
        d = rd_data;
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge clk); #1;
        while (fill_busy && n < 4000) begin
            @(negedge clk); #1; n++;
        end
    endtask

    task automatic pulse_inv(input bit b, input bit f, input int cyc);
        @(negedge clk);
        inv_bus = b; inv_flash = f;
        repeat (cyc) @(negedge clk);
        inv_bus = 1'b0; inv_flash = 1'b0;
    endtask

    function automatic int exp_len(input int u);
        if (u == 0) return 8;
        if (u * 8 > 1024) return 1024;
        return u * 8;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int w, rc, fc;
        repeat (3) @(negedge clk);
        #1;
        chk(!fill_busy && !fq_valid && !rd_ready, "R1 reset state", {fill_busy, fq_valid, rd_ready}, 0);
        rst_n = 1'b1;

        // First miss: 32-byte line, seq 5
        rc = req_cnt;
        rd(32'h1006, d, w);
        chk(req_cnt == rc + 1, "R2 one request on miss", req_cnt, rc + 1);
        chk(last_seq == 4'd5, "R2 sequence id", last_seq, 5);
        chk(last_addr == 32'h1004, "R2 aligned address", last_addr, 32'h1004);
        chk(last_len == 32, "R3 length 4 units", last_len, 32);
        chk(d == fword(32'h1004), "R4 byte lanes", d, fword(32'h1004));
        wait_idle();

        // Every byte address in the line hits with no request
        rc = req_cnt;
        for (int a = 32'h1004; a < 32'h1024; a++) begin
            rd(a, d, w);
            chk(w == 0, "R5 hit in first cycle", w, 0);
            chk(d == fword(a), "R5 hit data", d, fword(a));
        end
        chk(req_cnt == rc, "R5 no request on hits", req_cnt, rc);

        cfg_swap = 1'b1;
        rd(32'h1010, d, w);
        chk(d == {fword(32'h1010)[7:0], fword(32'h1010)[15:8], fword(32'h1010)[23:16], fword(32'h1010)[31:24]},
            "R4 swapped lanes", d, fword(32'h1010));
        cfg_swap = 1'b0;

        // Just past the end misses; then the old line misses too
        rc = req_cnt;
        rd(32'h1024, d, w);
        wait_idle();
        chk(req_cnt == rc + 1, "R10 end boundary misses", req_cnt, rc + 1);
        chk(d == fword(32'h1024), "R10 new line data", d, fword(32'h1024));
        rd(32'h1004, d, w);
        wait_idle();
        chk(req_cnt == rc + 2, "R10 old line replaced", req_cnt, rc + 2);

        // Length rule across unit counts
        foreach (exp_len_tab[i]) ;
        for (int k = 0; k < 6; k++) begin
            int u;
            u = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 7 : (k == 3) ? 200 : (k == 4) ? 255 : 128;
            cfg_units = 8'(u);
            cfg_seq = 4'(k + 8);
            rc = req_cnt; fc = fd_cnt;
            rd(32'h20002 + k * 32'h1000, d, w);
            wait_idle();
            chk(req_cnt == rc + 1, "R2 miss on new region", req_cnt, rc + 1);
            chk(last_seq == 4'(k + 8), "R2 seq follows config", last_seq, k + 8);
            chk(last_len == exp_len(u), "R3 length clamp", last_len, exp_len(u));
            chk(fd_cnt - fc == exp_len(u) / 4, "R7 all words absorbed", fd_cnt - fc, exp_len(u) / 4);
        end

        // Full 1024-byte line is all hits
        rc = req_cnt;
        for (int i = 0; i < 256; i++) begin
            rd(32'h25000 + i * 4, d, w);
            chk(w == 0 && d == fword(32'h25000 + i * 4), "R5 full line hit", d, fword(32'h25000 + i * 4));
        end
        chk(req_cnt == rc, "R5 no request in full line", req_cnt, rc);

        // Read overtaking a fill
        rc = req_cnt;
        rd(32'h40000, d, w);
        #1;
        chk(fill_busy == 1'b1, "R7 busy during fill", fill_busy, 1);
        rd(32'h403FC, d, w);
        chk(w > 0, "R6 stall until word arrives", w, 1);
        chk(d == fword(32'h403FC), "R6 data after stall", d, fword(32'h403FC));
        chk(req_cnt == rc + 1, "R6 no extra request", req_cnt, rc + 1);
        wait_idle();
        chk(!fill_busy, "R7 busy clears", fill_busy, 0);

        // Invalidate filter
        rc = req_cnt;
        pulse_inv(1'b1, 1'b0, 5);
        pulse_inv(1'b0, 1'b1, 5);
        pulse_inv(1'b1, 1'b1, 2);
        rd(32'h40010, d, w);
        chk(w == 0 && req_cnt == rc, "R9 short or single strobe ignored", req_cnt, rc);
        pulse_inv(1'b1, 1'b1, 3);
        rd(32'h40010, d, w);
        wait_idle();
        chk(req_cnt == rc + 1, "R8 invalidate forces miss", req_cnt, rc + 1);
        chk(d == fword(32'h40010), "R8 refetched data", d, fword(32'h40010));

        // Invalidate in the middle of a fill
        rc = req_cnt; fc = fd_cnt;
        rd(32'h60000, d, w);
        pulse_inv(1'b1, 1'b1, 3);
        wait_idle();
        chk(fd_cnt - fc == 256, "R11 remaining words absorbed", fd_cnt - fc, 256);
        chk(req_cnt == rc + 1, "R11 single request for fill", req_cnt, rc + 1);
        rd(32'h60000, d, w);
        wait_idle();
        chk(req_cnt == rc + 2, "R11 line not kept", req_cnt, rc + 2);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    int exp_len_tab[1];
endmodule